// File: doc/BRIEF.md
# Masked Register Cache Patch Engine

This engine works on a fixed list of 25 word-wide configuration registers of a serial receiver. It reaches them through a 32-bit memory-mapped master port. It knows three commands. A snapshot command reads every listed register into local storage. An apply command writes each stored word back after forcing selected bits through a per-entry pair of constant masks. A restore command writes the stored words back unchanged.

The forced word is always built from the snapshot and never from a fresh read. As a result, restore returns each register to the exact value it held before the apply command ran. The entry list and its masks are constant tables. The engine issues one bus operation at a time, in index order, and waits for that operation's response before it issues the next.

Apply and restore are accepted only once a snapshot exists and only while the receiver is held in reset. An input reports that reset condition to the engine.

Top module: `reg_patch_engine`

## Requirements
- R1: After reset, `busy`, `cmd_done`, `cmd_err`, `m_rd` and `m_wr` are all low.
- R2: A snapshot command (`cmd_op` = 0) reads indices 0 to 24 in order, at addresses 0x41450, 0x41584, 0x415DC, 0x41674, 0x4167C, 0x41680, 0x41684, 0x41758, 0x4175C, 0x41808, 0x41938, 0x4193C, 0x41960, 0x419B4, 0x419B8, 0x41A88, 0x41A8C, 0x41A90, 0x41A94, 0x41A98, 0x41A9C, 0x41AA4, 0x41C10, 0x41C14, 0x41C64. No new request is raised until `m_rvalid` has returned for the previous one.
- R3: While `m_wait` is high, a raised request stays raised with an unchanged address, direction and write data.
- R4: An apply command (`cmd_op` = 1) writes (snapshot | S) & K to each address in index order. Per index, S/K are: 0:00040000/FFFFFFFF, 1:00004000/FFFF7FFF, 2:0/CFFFFFFF, 3:0/87FFFFFF, 4:03C00000/FFFFFFFF, 5:0/3FFFFFFF, 6:0/27FFFFFF, 7:60000000/FFFFFFFF, 8:0003C000/FFFFFFFF, 9:00010000/FFFF7FFF, 10:FF0C5504/FFFF55F7, 11:000000FF/FFFFFFFF, 12:20000000/FFFFFFFF, 13:10000000/FFFFFFFF, 14:08000000/FFFFFFFF, 15:68000000/EFFFFFFF, 16:68000000/EFFFFFFF, 17:18000000/FFFFFFFF, 18:20000000/BFFFFFFF, 19:38000000/BFFFFFFF, 20:F403D00F/F7FFDFFF, 21:3E7E4000/FE7E7FFF, 22:46610000/466100FF, 23:05523423/F5523423, 24:1EE8F900/FEEFF9FF. Each write waits for `m_wack` before the next one is issued.
- R5: After apply, register 0x41AA4 holds 0xF9 in bits [29:22] and 0xF9 in bits [21:14]. Register 0x41584 holds 1 in bits [15:14], 0x41960 has bit 29 set, and 0x415DC has bits [29:28] clear.
- R6: A restore command (`cmd_op` = 2) writes the snapshot words unchanged, in index order, so every register regains the value it had at snapshot time.
- R7: If an apply or restore command arrives before any snapshot has completed, the engine raises `cmd_err` for exactly one cycle in the cycle after `cmd_start`. It makes no bus request and does not raise `cmd_done`.
- R8: If an apply or restore command arrives while `rx_held` is low, the engine rejects it in the same way as in R7. A snapshot command is accepted whatever the level of `rx_held`.
- R9: `cmd_done` is high for exactly one cycle, in the cycle after the last response of a command is taken. `busy` is low in that cycle.
- R10: A `cmd_start` that arrives while `busy` is high is ignored. The running command still makes exactly 25 bus operations, and no further operation follows it.
- R11: Op code 3 is reserved. A command with op code 3 is rejected with a one-cycle `cmd_err` and makes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, sampled while idle |
| cmd_op | input | 2 | 0 snapshot, 1 apply, 2 restore, 3 reserved |
| rx_held | input | 1 | High while the receiver is held in reset |
| busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle pulse when a command completes |
| cmd_err | output | 1 | One-cycle pulse when a command is rejected |
| m_addr | output | ADDR_W | Master address |
| m_rd | output | 1 | Read request |
| m_wr | output | 1 | Write request |
| m_wdata | output | DATA_W | Write data |
| m_wait | input | 1 | Request is stalled by the slave |
| m_rdata | input | DATA_W | Read data |
| m_rvalid | input | 1 | Read data valid |
| m_wack | input | 1 | Write response |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of a restore. That restore must also be running with both a stall and a long response latency, and it must be checked that the stray start neither adds a bus operation nor disturbs the index order. The bench sets its slave model to stall each request and delay each response by several cycles. It then pulses a snapshot start partway through the restore. Its scoreboard expects exactly the 25 restore writes and flags any extra operation that arrives with no expected item waiting. The same slave model checks that a request is held steady through each stall and that no new request appears before the previous response.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

    localparam int unsigned ENTRY_COUNT = 25;
    localparam int unsigned TBL_W       = 32;

    typedef enum logic [1:0] {
        OP_CACHE  = 2'd0,
        OP_PATCH  = 2'd1,
        OP_REVERT = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        logic [TBL_W-1:0] addr;
        logic [TBL_W-1:0] set_m;
        logic [TBL_W-1:0] keep_m;
    } entry_t;

    // Constant entry table: address, bits forced high, bits allowed to survive.
    function automatic entry_t entry_lookup(input int unsigned i);
        entry_t e;
        case (i)
            0:  e = '{32'h0004_1450, 32'h0004_0000, 32'hFFFF_FFFF};
            1:  e = '{32'h0004_1584, 32'h0000_4000, 32'hFFFF_7FFF};
            2:  e = '{32'h0004_15DC, 32'h0000_0000, 32'hCFFF_FFFF};
            3:  e = '{32'h0004_1674, 32'h0000_0000, 32'h87FF_FFFF};
            4:  e = '{32'h0004_167C, 32'h03C0_0000, 32'hFFFF_FFFF};
            5:  e = '{32'h0004_1680, 32'h0000_0000, 32'h3FFF_FFFF};
            6:  e = '{32'h0004_1684, 32'h0000_0000, 32'h27FF_FFFF};
            7:  e = '{32'h0004_1758, 32'h6000_0000, 32'hFFFF_FFFF};
            8:  e = '{32'h0004_175C, 32'h0003_C000, 32'hFFFF_FFFF};
            9:  e = '{32'h0004_1808, 32'h0001_0000, 32'hFFFF_7FFF};
            10: e = '{32'h0004_1938, 32'hFF0C_5504, 32'hFFFF_55F7};
            11: e = '{32'h0004_193C, 32'h0000_00FF, 32'hFFFF_FFFF};
            12: e = '{32'h0004_1960, 32'h2000_0000, 32'hFFFF_FFFF};
            13: e = '{32'h0004_19B4, 32'h1000_0000, 32'hFFFF_FFFF};
            14: e = '{32'h0004_19B8, 32'h0800_0000, 32'hFFFF_FFFF};
            15: e = '{32'h0004_1A88, 32'h6800_0000, 32'hEFFF_FFFF};
            16: e = '{32'h0004_1A8C, 32'h6800_0000, 32'hEFFF_FFFF};
            17: e = '{32'h0004_1A90, 32'h1800_0000, 32'hFFFF_FFFF};
            18: e = '{32'h0004_1A94, 32'h2000_0000, 32'hBFFF_FFFF};
            19: e = '{32'h0004_1A98, 32'h3800_0000, 32'hBFFF_FFFF};
            20: e = '{32'h0004_1A9C, 32'hF403_D00F, 32'hF7FF_DFFF};
            21: e = '{32'h0004_1AA4, 32'h3E7E_4000, 32'hFE7E_7FFF};
            22: e = '{32'h0004_1C10, 32'h4661_0000, 32'h4661_00FF};
            23: e = '{32'h0004_1C14, 32'h0552_3423, 32'hF552_3423};
            24: e = '{32'h0004_1C64, 32'h1EE8_F900, 32'hFEEF_F9FF};
            default: e = '{32'h0, 32'h0, 32'hFFFF_FFFF};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rpe_entry_rom.sv
module rpe_entry_rom
    import rpe_pkg::*;
#(
    parameter int unsigned N_ENTRIES = ENTRY_COUNT,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] set_o,
    output logic [DATA_W-1:0] keep_o
);

    logic [ADDR_W-1:0] addr_tbl [N_ENTRIES];
    logic [DATA_W-1:0] set_tbl  [N_ENTRIES];
    logic [DATA_W-1:0] keep_tbl [N_ENTRIES];

    for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_row
        localparam entry_t ROW = entry_lookup(g);
        assign addr_tbl[g] = ADDR_W'(ROW.addr);
        assign set_tbl[g]  = DATA_W'(ROW.set_m);
        assign keep_tbl[g] = DATA_W'(ROW.keep_m);
    end

    always_comb begin
        addr_o = '0;
        set_o  = '0;
        keep_o = '1;
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            if (idx_i == IDX_W'(i)) begin
                addr_o = addr_tbl[i];
                set_o  = set_tbl[i];
                keep_o = keep_tbl[i];
            end
        end
    end

endmodule

// File: rtl/rpe_snapshot.sv
module rpe_snapshot #(
    parameter int unsigned N_ENTRIES = 25,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] word_q [N_ENTRIES];
    logic [DATA_W-1:0] word_d [N_ENTRIES];

    always_comb begin
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            word_d[i] = word_q[i];
            if (wr_en_i && (idx_i == IDX_W'(i))) begin
                word_d[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= word_d[i];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            if (idx_i == IDX_W'(i)) begin
                rd_data_o = word_q[i];
            end
        end
    end

endmodule

// File: rtl/rpe_sequencer.sv
module rpe_sequencer
    import rpe_pkg::*;
#(
    parameter int unsigned N_ENTRIES = ENTRY_COUNT,
    parameter int unsigned IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic             rx_held_i,
    input  logic             bus_wait_i,
    input  logic             rvalid_i,
    input  logic             wack_i,
    output logic [IDX_W-1:0] idx_o,
    output op_e              op_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             store_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
        op_e              op;
        logic             have_snap;
        logic             done;
        logic             err;
    } seq_s;

    seq_s seq_q, seq_d;
    op_e  op_req;
    logic reject;
    logic resp;

    always_comb begin
        op_req    = op_e'(op_i);
        seq_d     = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        store_o   = 1'b0;
        reject    = (op_req == OP_RSVD) ||
                    ((op_req != OP_CACHE) && (!seq_q.have_snap || !rx_held_i));
        resp      = (seq_q.op == OP_CACHE) ? rvalid_i : wack_i;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (reject) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st  = ST_ISSUE;
                        seq_d.idx = '0;
                        seq_d.op  = op_req;
                        if (op_req == OP_CACHE) begin
                            seq_d.have_snap = 1'b0;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                if (!bus_wait_i) begin
                    seq_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (resp) begin
                    store_o = (seq_q.op == OP_CACHE);
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        if (seq_q.op == OP_CACHE) begin
                            seq_d.have_snap = 1'b1;
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                        seq_d.st  = ST_ISSUE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, idx: '0, op: OP_CACHE,
                       have_snap: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o  = seq_q.idx;
    assign op_o   = seq_q.op;
    assign rd_o   = (seq_q.st == ST_ISSUE) && (seq_q.op == OP_CACHE);
    assign wr_o   = (seq_q.st == ST_ISSUE) && (seq_q.op != OP_CACHE);
    assign busy_o = (seq_q.st != ST_IDLE);
    assign done_o = seq_q.done;
    assign err_o  = seq_q.err;

    // R3: a stalled request keeps its index and direction
    a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_o || wr_o) && bus_wait_i) |=> ((rd_o || wr_o) && $stable(idx_o) && $stable(op_o)));

    // R9: done is a single-cycle pulse following a taken response
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rvalid_i || wack_i) && !busy_o));

    // R7: no write is ever issued without a completed snapshot
    a_r7_write_needs_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> seq_q.have_snap);

    // R8: an accepted write command was started with the receiver held
    a_r8_write_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && (op_o != OP_CACHE)) |-> $past(rx_held_i));

    // R11: a rejection never coincides with bus traffic
    a_r11_err_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!rd_o && !wr_o && !busy_o));

endmodule

// File: rtl/reg_patch_engine.sv
module reg_patch_engine
    import rpe_pkg::*;
#(
    parameter int unsigned N_ENTRIES = ENTRY_COUNT,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              rx_held,
    output logic              busy,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_rd,
    output logic              m_wr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_wait,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rvalid,
    input  logic              m_wack
);

    localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    logic [IDX_W-1:0]  cur_idx;
    op_e               cur_op;
    logic              store_en;
    logic [DATA_W-1:0] snap_word;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] keep_mask;

    rpe_sequencer #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cmd_start),
        .op_i       (cmd_op),
        .rx_held_i  (rx_held),
        .bus_wait_i (m_wait),
        .rvalid_i   (m_rvalid),
        .wack_i     (m_wack),
        .idx_o      (cur_idx),
        .op_o       (cur_op),
        .rd_o       (m_rd),
        .wr_o       (m_wr),
        .store_o    (store_en),
        .busy_o     (busy),
        .done_o     (cmd_done),
        .err_o      (cmd_err)
    );

    rpe_entry_rom #(
        .N_ENTRIES (N_ENTRIES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_rom (
        .idx_i  (cur_idx),
        .addr_o (m_addr),
        .set_o  (set_mask),
        .keep_o (keep_mask)
    );

    rpe_snapshot #(
        .N_ENTRIES (N_ENTRIES),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (store_en),
        .idx_i     (cur_idx),
        .wr_data_i (m_rdata),
        .rd_data_o (snap_word)
    );

    always_comb begin
        if (cur_op == OP_PATCH) begin
            m_wdata = (snap_word | set_mask) & keep_mask;
        end else begin
            m_wdata = snap_word;
        end
    end

    // R2: reads and writes are never raised together
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rd && m_wr));

    // R3: write data stays put during a stall
    a_r3_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr && m_wait) |=> $stable(m_wdata));

endmodule

// File: tb/test_reg_patch_engine.sv
`timescale 1ns/1ps
module test_reg_patch_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start;
    logic [1:0]  cmd_op;
    logic        rx_held;
    logic        busy, cmd_done, cmd_err;
    logic [31:0] m_addr;
    logic        m_rd, m_wr;
    logic [31:0] m_wdata;
    logic        m_wait;
    logic [31:0] m_rdata;
    logic        m_rvalid, m_wack;

    always #10 clk = ~clk;

    reg_patch_engine i_reg_patch_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .rx_held(rx_held), .busy(busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata),
        .m_wait(m_wait), .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_wack(m_wack)
    );

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    exp_t        e_item;
    logic [31:0] tb_addr [25];
    logic [31:0] tb_set  [25];
    logic [31:0] tb_keep [25];
    logic [31:0] shadow  [25];
    logic [31:0] orig    [25];
    logic [31:0] snap_m  [25];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          txn = 0;
    int          last_rsp = 0;
    int          stall_n = 0;
    int          lat_n = 0;
    bit          r_wr;
    logic [31:0] r_addr, r_data;
    int          r_idx;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int find_idx(input logic [31:0] a);
        for (int i = 0; i < 25; i++) if (tb_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic set_row(input int i, input logic [31:0] a,
                           input logic [31:0] s, input logic [31:0] k);
        tb_addr[i] = a; tb_set[i] = s; tb_keep[i] = k;
    endtask

    // slave model and monitor: pops expected items as operations appear
    initial begin
        m_wait = 1'b0; m_rvalid = 1'b0; m_wack = 1'b0; m_rdata = '0;
        forever begin
            @(negedge clk);
            m_rvalid = 1'b0;
            m_wack   = 1'b0;
            if (rst_n && (m_rd || m_wr)) begin
                r_wr = m_wr; r_addr = m_addr; r_data = m_wdata;
                for (int k = 0; k < stall_n; k++) begin
                    m_wait = 1'b1;
                    @(negedge clk);
                    check("R3", "request held in stall", {30'd0, m_rd, m_wr}, {30'd0, !r_wr, r_wr});
                    check("R3", "address held in stall", m_addr, r_addr);
                    if (r_wr) check("R3", "wdata held in stall", m_wdata, r_data);
                end
                m_wait = 1'b0;
                if (expq.size() == 0) begin
                    check("R10", "unexpected bus operation", r_addr, 32'hFFFF_FFFF);
                end else begin
                    e_item = expq.pop_front();
                    check(e_item.tag, "direction", {31'd0, r_wr}, {31'd0, e_item.wr});
                    check(e_item.tag, "address", r_addr, e_item.addr);
                    if (e_item.wr) check(e_item.tag, "write data", r_data, e_item.data);
                end
                r_idx = find_idx(r_addr);
                if (r_wr && r_idx >= 0) shadow[r_idx] = r_data;
                txn++;
                @(negedge clk);
                check("R2", "no request before response", {30'd0, m_rd, m_wr}, 32'd0);
                for (int k = 0; k < lat_n; k++) @(negedge clk);
                if (r_wr) begin
                    m_wack = 1'b1;
                end else begin
                    m_rdata  = (r_idx >= 0) ? shadow[r_idx] : 32'hDEAD_BEEF;
                    m_rvalid = 1'b1;
                end
                last_rsp = cyc;
            end
        end
    end

    task automatic push_cache(input string tag);
        for (int i = 0; i < 25; i++) begin
            snap_m[i] = shadow[i];
            expq.push_back('{1'b0, tb_addr[i], 32'd0, tag});
        end
    endtask

    task automatic push_patch();
        for (int i = 0; i < 25; i++)
            expq.push_back('{1'b1, tb_addr[i], (snap_m[i] | tb_set[i]) & tb_keep[i], "R4"});
    endtask

    task automatic push_revert();
        for (int i = 0; i < 25; i++)
            expq.push_back('{1'b1, tb_addr[i], snap_m[i], "R6"});
    endtask

    task automatic run_cmd(input logic [1:0] op, input string tag, input bit poke);
        int t0;
        int waited;
        t0 = txn;
        waited = 0;
        cmd_op = op; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(tag, "busy after start", {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (8) @(negedge clk);
            cmd_op = 2'd0; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (!cmd_done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R9", "done pulse cycle", cyc, last_rsp + 1);
        check("R9", "busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R9", "done falls after one cycle", {31'd0, cmd_done}, 32'd0);
        repeat (20) @(negedge clk);
        check(poke ? "R10" : tag, "operation count", txn - t0, 25);
        check(tag, "scoreboard drained", expq.size(), 0);
    endtask

    task automatic expect_reject(input logic [1:0] op, input string tag);
        int t0;
        t0 = txn;
        cmd_op = op; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(tag, "err raised", {31'd0, cmd_err}, 32'd1);
        check(tag, "busy stays low", {31'd0, busy}, 32'd0);
        check(tag, "no done on reject", {31'd0, cmd_done}, 32'd0);
        @(negedge clk);
        check(tag, "err one cycle", {31'd0, cmd_err}, 32'd0);
        repeat (4) @(negedge clk);
        check(tag, "no bus traffic", txn - t0, 0);
    endtask

    initial begin : main
        set_row(0,  32'h41450, 32'h00040000, 32'hFFFFFFFF);
        set_row(1,  32'h41584, 32'h00004000, 32'hFFFF7FFF);
        set_row(2,  32'h415DC, 32'h00000000, 32'hCFFFFFFF);
        set_row(3,  32'h41674, 32'h00000000, 32'h87FFFFFF);
        set_row(4,  32'h4167C, 32'h03C00000, 32'hFFFFFFFF);
        set_row(5,  32'h41680, 32'h00000000, 32'h3FFFFFFF);
        set_row(6,  32'h41684, 32'h00000000, 32'h27FFFFFF);
        set_row(7,  32'h41758, 32'h60000000, 32'hFFFFFFFF);
        set_row(8,  32'h4175C, 32'h0003C000, 32'hFFFFFFFF);
        set_row(9,  32'h41808, 32'h00010000, 32'hFFFF7FFF);
        set_row(10, 32'h41938, 32'hFF0C5504, 32'hFFFF55F7);
        set_row(11, 32'h4193C, 32'h000000FF, 32'hFFFFFFFF);
        set_row(12, 32'h41960, 32'h20000000, 32'hFFFFFFFF);
        set_row(13, 32'h419B4, 32'h10000000, 32'hFFFFFFFF);
        set_row(14, 32'h419B8, 32'h08000000, 32'hFFFFFFFF);
        set_row(15, 32'h41A88, 32'h68000000, 32'hEFFFFFFF);
        set_row(16, 32'h41A8C, 32'h68000000, 32'hEFFFFFFF);
        set_row(17, 32'h41A90, 32'h18000000, 32'hFFFFFFFF);
        set_row(18, 32'h41A94, 32'h20000000, 32'hBFFFFFFF);
        set_row(19, 32'h41A98, 32'h38000000, 32'hBFFFFFFF);
        set_row(20, 32'h41A9C, 32'hF403D00F, 32'hF7FFDFFF);
        set_row(21, 32'h41AA4, 32'h3E7E4000, 32'hFE7E7FFF);
        set_row(22, 32'h41C10, 32'h46610000, 32'h466100FF);
        set_row(23, 32'h41C14, 32'h05523423, 32'hF5523423);
        set_row(24, 32'h41C64, 32'h1EE8F900, 32'hFEEFF9FF);
        for (int i = 0; i < 25; i++) begin
            shadow[i] = (32'h9E3779B9 * (i + 1)) ^ 32'h5A5AA5A5;
            orig[i]   = shadow[i];
        end

        rst_n = 1'b0; cmd_start = 1'b0; cmd_op = 2'd0; rx_held = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "outputs in reset", {27'd0, busy, cmd_done, cmd_err, m_rd, m_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "outputs after reset", {27'd0, busy, cmd_done, cmd_err, m_rd, m_wr}, 32'd0);

        rx_held = 1'b1;
        expect_reject(2'd1, "R7");
        expect_reject(2'd2, "R7");

        stall_n = 2; lat_n = 1;
        push_cache("R2");
        run_cmd(2'd0, "R2", 1'b0);

        rx_held = 1'b0;
        expect_reject(2'd1, "R8");
        expect_reject(2'd2, "R8");
        rx_held = 1'b1;
        expect_reject(2'd3, "R11");

        stall_n = 0; lat_n = 0;
        push_patch();
        run_cmd(2'd1, "R4", 1'b0);
        check("R5", "0x41AA4 [29:22]", {24'd0, shadow[21][29:22]}, 32'hF9);
        check("R5", "0x41AA4 [21:14]", {24'd0, shadow[21][21:14]}, 32'hF9);
        check("R5", "0x41584 [15:14]", {30'd0, shadow[1][15:14]}, 32'd1);
        check("R5", "0x41960 bit 29", {31'd0, shadow[12][29]}, 32'd1);
        check("R5", "0x415DC [29:28]", {30'd0, shadow[2][29:28]}, 32'd0);

        stall_n = 1; lat_n = 3;
        push_revert();
        run_cmd(2'd2, "R6", 1'b1);
        for (int i = 0; i < 25; i++) check("R6", "restored word", shadow[i], orig[i]);

        rx_held = 1'b0; stall_n = 0; lat_n = 2;
        push_cache("R8");
        run_cmd(2'd0, "R8", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule